// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block arbitrates eight maskable interrupt sources, one non-maskable input and one software trap for a small processor core. Each maskable source has a pending latch and an enable bit. Software sets priorities through a 24-bit map. The map holds eight 3-bit fields, one per priority level, and each field names the source code that owns that level. Every cycle the controller picks the highest-level request that can be serviced. It issues that request's vector on a one-cycle strobe and records the level as in service.

Nesting is tracked as a set of in-service levels. A new request interrupts the current routine only when its level is strictly above every level already in service. A return strobe retires the most recent, highest level. The trap sits above everything, ignores the global enable and cannot be interrupted. The non-maskable input sits just below the trap and ignores the enable bits. Stacking, flag saving and vector fetch belong to the core.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After synchronous reset, `irq_valid` and `in_service` are 0, all enable bits are 0 and the map is all zeros. With an all-zero map only source 0 owns a level (level 7), so every other source code is unassigned.
- R2: Address 0 holds the enable register, with bit s enabling source s when set. A request from a disabled source stays pending. Once its bit is written to 1, it is granted two clock edges after the write is presented, if no equal or higher level is in service.
- R3: Address 1 writes map bits 23:16, address 2 writes bits 15:8 and address 3 writes bits 7:0. The field for level L is bits 3L+2:3L, and level 7 ranks highest among the configurable levels.
- R4: When several serviceable requests are pending together, the one at the highest level is granted first.
- R5: A request preempts the routine in service only if its level is strictly higher. A request at an equal or lower level waits.
- R6: A one-cycle `rti` pulse retires the highest level in service. A request that was waiting is then granted two edges after the pulse is presented.
- R7: The trap is granted with vector 9 even while `gie` is 0. No request is granted while the trap routine is in service.
- R8: The non-maskable input is granted with vector 8, above every configurable level and below the trap. It ignores the enable bits but is held pending while `gie` is 0.
- R9: A `clr_en` pulse with `clr_code` = s drops the pending request of source s, so it is never granted.
- R10: Map writes are ignored while any level is in service. Enable-register writes are always accepted.
- R11: If a code appears in more than one field, the highest level holding it sets that source's level. A source whose code is in no field is never granted.
- R12: A request pulse presented before edge k is latched at edge k and granted at edge k+1. `irq_valid` is then high for exactly one cycle, with `irq_vector` 0 to 7 for a configurable source's code.
- R13: While `gie` is 0, configurable requests stay pending and are granted once `gie` returns to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration address: 0 enable, 1 to 3 map bytes |
| cfg_wdata | input | 8 | Configuration write data |
| src_req | input | 8 | Request pulses, one bit per source code |
| nmi_req | input | 1 | Non-maskable request pulse |
| trap_req | input | 1 | Software trap request pulse |
| gie | input | 1 | Global enable for non-trap requests |
| rti | input | 1 | Return-from-interrupt pulse |
| clr_en | input | 1 | Clear-pending pulse |
| clr_code | input | 3 | Source code to clear |
| irq_valid | output | 1 | One-cycle grant strobe |
| irq_vector | output | 4 | Granted vector: 0-7 source, 8 non-maskable, 9 trap |
| in_service | output | 1 | Some level is in service |

## Verification
The assertions assume that `rti` is pulsed only while a routine is in service and never in the same cycle as a grant. They also assume that every input is a clean synchronous level once reset is released. The stimulus issues each return only after the grant it answers has been observed, and it leaves one idle cycle after every pulse. The map is rewritten only through the normal write port, so the lock check sees map changes only where the hardware allows them.

// File: rtl/pic_pkg.sv
package pic_pkg;
  // default number of configurable sources (and configurable levels)
  localparam int unsigned DEF_NSRC   = 8;
  // default configuration address width
  localparam int unsigned DEF_CFG_AW = 2;
  // configuration data bus width
  localparam int unsigned CFG_DW     = 8;
endpackage

// File: rtl/pic_cfg_regs.sv
module pic_cfg_regs #(
  parameter int NSRC   = pic_pkg::DEF_NSRC,
  parameter int CODE_W = $clog2(NSRC),
  parameter int ADDR_W = pic_pkg::DEF_CFG_AW,
  localparam int MAP_W     = NSRC * CODE_W,
  localparam int MAP_BYTES = (MAP_W + 7) / 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      we,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [pic_pkg::CFG_DW-1:0] wdata,
  input  logic                      map_lock,
  output logic [NSRC-1:0]           mask_q,
  output logic [MAP_W-1:0]          map_q
);
  logic [MAP_BYTES*8-1:0] map_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      map_r  <= '0;
    end else if (we) begin
      if (addr == '0) begin
        mask_q <= wdata[NSRC-1:0];
      end else if (!map_lock) begin
        // address 1 holds the most significant byte of the map
        for (int b = 0; b < MAP_BYTES; b++) begin
          if (int'(addr) == MAP_BYTES - b) map_r[b*8 +: 8] <= wdata;
        end
      end
    end
  end

  assign map_q = map_r[MAP_W-1:0];
endmodule

// File: rtl/pic_pending.sv
module pic_pending #(
  parameter int NSRC   = pic_pkg::DEF_NSRC,
  parameter int CODE_W = $clog2(NSRC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   src_req,
  input  logic              nmi_req,
  input  logic              trap_req,
  input  logic              clr_en,
  input  logic [CODE_W-1:0] clr_code,
  input  logic [NSRC-1:0]   gnt_src,
  input  logic              gnt_nmi,
  input  logic              gnt_trap,
  output logic [NSRC-1:0]   pend_q,
  output logic              nmi_pend_q,
  output logic              trap_pend_q
);
  logic [NSRC-1:0] pend_d;

  // a fresh request wins over a grant or a clear in the same cycle
  for (genvar s = 0; s < NSRC; s++) begin : g_src
    logic drop;
    assign drop      = gnt_src[s] | (clr_en & (clr_code == CODE_W'(s)));
    assign pend_d[s] = src_req[s] | (pend_q[s] & ~drop);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q      <= '0;
      nmi_pend_q  <= 1'b0;
      trap_pend_q <= 1'b0;
    end else begin
      pend_q      <= pend_d;
      nmi_pend_q  <= nmi_req  | (nmi_pend_q  & ~gnt_nmi);
      trap_pend_q <= trap_req | (trap_pend_q & ~gnt_trap);
    end
  end
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter #(
  parameter int NSRC   = pic_pkg::DEF_NSRC,
  parameter int CODE_W = $clog2(NSRC),
  parameter int VEC_W  = $clog2(NSRC + 2),
  localparam int NLVL  = NSRC + 2,
  localparam int MAP_W = NSRC * CODE_W
) (
  input  logic [MAP_W-1:0] map_q,
  input  logic [NSRC-1:0]  pend,
  input  logic [NSRC-1:0]  mask,
  input  logic             nmi_pend,
  input  logic             trap_pend,
  input  logic             gie,
  input  logic [NLVL-1:0]  stack_q,
  output logic             win_valid,
  output logic [VEC_W-1:0] win_vec,
  output logic [NLVL-1:0]  win_lvl_oh
);
  logic [NLVL-1:0] allowed;
  logic [NLVL-1:0] cand;

  // a level may be entered only if it is above every level in service
  for (genvar l = 0; l < NLVL; l++) begin : g_allow
    assign allowed[l] = ~|(stack_q >> l);
  end

  for (genvar l = 0; l < NSRC; l++) begin : g_lvl
    logic [CODE_W-1:0] code;
    logic              own;
    assign code = map_q[l*CODE_W +: CODE_W];
    // a level counts only if no higher level carries the same code
    always_comb begin
      own = 1'b1;
      for (int m = l + 1; m < NSRC; m++) begin
        if (map_q[m*CODE_W +: CODE_W] == code) own = 1'b0;
      end
    end
    assign cand[l] = own & pend[code] & mask[code] & gie & allowed[l];
  end

  assign cand[NSRC]   = nmi_pend & gie & allowed[NSRC];
  assign cand[NSRC+1] = trap_pend & allowed[NSRC+1];

  // highest candidate level wins
  always_comb begin
    win_valid  = 1'b0;
    win_vec    = '0;
    win_lvl_oh = '0;
    for (int l = 0; l < NLVL; l++) begin
      if (cand[l]) begin
        win_valid     = 1'b1;
        win_lvl_oh    = '0;
        win_lvl_oh[l] = 1'b1;
        if (l < NSRC) win_vec = VEC_W'(map_q[l*CODE_W +: CODE_W]);
        else          win_vec = VEC_W'(l);
      end
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NSRC   = pic_pkg::DEF_NSRC,
  parameter int CFG_AW = pic_pkg::DEF_CFG_AW,
  localparam int CODE_W = $clog2(NSRC),
  localparam int NLVL   = NSRC + 2,
  localparam int VEC_W  = $clog2(NLVL),
  localparam int MAP_W  = NSRC * CODE_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cfg_we,
  input  logic [CFG_AW-1:0]          cfg_addr,
  input  logic [pic_pkg::CFG_DW-1:0] cfg_wdata,
  input  logic [NSRC-1:0]            src_req,
  input  logic                       nmi_req,
  input  logic                       trap_req,
  input  logic                       gie,
  input  logic                       rti,
  input  logic                       clr_en,
  input  logic [CODE_W-1:0]          clr_code,
  output logic                       irq_valid,
  output logic [VEC_W-1:0]           irq_vector,
  output logic                       in_service
);
  logic [NSRC-1:0]  mask_q;
  logic [MAP_W-1:0] map_q;
  logic [NSRC-1:0]  pend_q;
  logic             nmi_pend_q;
  logic             trap_pend_q;
  logic [NLVL-1:0]  stack_q;
  logic [NLVL-1:0]  ret_clr;
  logic             win_valid;
  logic [VEC_W-1:0] win_vec;
  logic [NLVL-1:0]  win_lvl_oh;
  logic [NSRC-1:0]  gnt_src;
  logic             gnt_nmi;
  logic             gnt_trap;

  pic_cfg_regs #(.NSRC(NSRC), .CODE_W(CODE_W), .ADDR_W(CFG_AW)) cfg_i (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .map_lock(in_service), .mask_q(mask_q), .map_q(map_q)
  );

  pic_pending #(.NSRC(NSRC), .CODE_W(CODE_W)) pend_i (
    .clk(clk), .rst(rst), .src_req(src_req), .nmi_req(nmi_req),
    .trap_req(trap_req), .clr_en(clr_en), .clr_code(clr_code),
    .gnt_src(gnt_src), .gnt_nmi(gnt_nmi), .gnt_trap(gnt_trap),
    .pend_q(pend_q), .nmi_pend_q(nmi_pend_q), .trap_pend_q(trap_pend_q)
  );

  pic_arbiter #(.NSRC(NSRC), .CODE_W(CODE_W), .VEC_W(VEC_W)) arb_i (
    .map_q(map_q), .pend(pend_q), .mask(mask_q), .nmi_pend(nmi_pend_q),
    .trap_pend(trap_pend_q), .gie(gie), .stack_q(stack_q),
    .win_valid(win_valid), .win_vec(win_vec), .win_lvl_oh(win_lvl_oh)
  );

  // grant decode back to the pending latches
  always_comb begin
    gnt_src = '0;
    if (win_valid && (win_lvl_oh[NSRC-1:0] != '0)) gnt_src[win_vec[CODE_W-1:0]] = 1'b1;
  end
  assign gnt_nmi  = win_lvl_oh[NSRC];
  assign gnt_trap = win_lvl_oh[NSRC+1];

  // return retires the topmost level in service
  always_comb begin
    ret_clr = '0;
    for (int l = 0; l < NLVL; l++) begin
      if (stack_q[l]) begin
        ret_clr    = '0;
        ret_clr[l] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stack_q    <= '0;
      irq_valid  <= 1'b0;
      irq_vector <= '0;
    end else begin
      stack_q   <= (stack_q & ~(rti ? ret_clr : '0)) | win_lvl_oh;
      irq_valid <= win_valid;
      if (win_valid) irq_vector <= win_vec;
    end
  end

  assign in_service = |stack_q;
endmodule

// File: rtl/pic_chk.sv
module pic_chk #(
  parameter int NSRC   = pic_pkg::DEF_NSRC,
  parameter int CODE_W = $clog2(NSRC),
  parameter int VEC_W  = $clog2(NSRC + 2),
  parameter int MAP_W  = NSRC * CODE_W
) (
  input logic             clk,
  input logic             rst,
  input logic             gie,
  input logic             rti,
  input logic             irq_valid,
  input logic [VEC_W-1:0] irq_vector,
  input logic             in_service,
  input logic             trap_busy,
  input logic [NSRC-1:0]  mask_q,
  input logic [MAP_W-1:0] map_q
);
  logic [NSRC-1:0] mask_d;
  always_ff @(posedge clk) mask_d <= mask_q;

  // R12
  vec_range_chk: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> (irq_vector < VEC_W'(NSRC + 2)));

  // R2
  mask_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_valid && irq_vector < VEC_W'(NSRC)) |-> mask_d[irq_vector[CODE_W-1:0]]);

  // R8
  nmi_gie_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_valid && irq_vector == VEC_W'(NSRC)) |-> $past(gie));

  // R7
  trap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (trap_busy && !rti) |=> !irq_valid);

  // R10
  map_lock_chk: assert property (@(posedge clk) disable iff (rst)
    in_service |=> $stable(map_q));

  // R5
  svc_mark_chk: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> in_service);
endmodule

bind prio_irq_ctrl pic_chk #(
  .NSRC(NSRC), .CODE_W(CODE_W), .VEC_W(VEC_W), .MAP_W(MAP_W)
) chk_i (
  .clk(clk), .rst(rst), .gie(gie), .rti(rti), .irq_valid(irq_valid),
  .irq_vector(irq_vector), .in_service(in_service),
  .trap_busy(stack_q[NLVL-1]), .mask_q(mask_q), .map_q(map_q)
);

// File: tb/prio_irq_ctrl_tb_top.sv
module prio_irq_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] src_req = '0;
  logic       nmi_req = 1'b0;
  logic       trap_req = 1'b0;
  logic       gie = 1'b1;
  logic       rti = 1'b0;
  logic       clr_en = 1'b0;
  logic [2:0] clr_code = '0;
  logic       irq_valid;
  logic [3:0] irq_vector;
  logic       in_service;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  prio_irq_ctrl dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .src_req(src_req), .nmi_req(nmi_req),
    .trap_req(trap_req), .gie(gie), .rti(rti), .clr_en(clr_en),
    .clr_code(clr_code), .irq_valid(irq_valid), .irq_vector(irq_vector),
    .in_service(in_service)
  );

  // entry: {rti, trap, nmi, req[7:0], exp_valid, exp_vec[3:0]}
  // map under test gives source s the level 7-s
  localparam logic [15:0] STEPS [21] = '{
    {1'b0, 1'b0, 1'b0, 8'h08, 1'b1, 4'd3},
    {1'b0, 1'b0, 1'b0, 8'h20, 1'b0, 4'd0},
    {1'b0, 1'b0, 1'b0, 8'h02, 1'b1, 4'd1},
    {1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 4'd0},
    {1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 4'd5},
    {1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 4'd0},
    {1'b0, 1'b0, 1'b0, 8'h81, 1'b1, 4'd0},
    {1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 4'd7},
    {1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 4'd0},
    {1'b0, 1'b0, 1'b1, 8'h00, 1'b1, 4'd8},
    {1'b0, 1'b0, 1'b0, 8'h01, 1'b0, 4'd0},
    {1'b0, 1'b1, 1'b0, 8'h00, 1'b1, 4'd9},
    {1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 4'd0},
    {1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 4'd0},
    {1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 4'd8},
    {1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 4'd0},
    {1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 4'd0},
    {1'b0, 1'b0, 1'b0, 8'h08, 1'b1, 4'd3},
    {1'b0, 1'b0, 1'b0, 8'h08, 1'b0, 4'd0},
    {1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 4'd3},
    {1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 4'd0}
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cfg_wr(input logic [1:0] a, input logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic map_wr(input logic [23:0] m);
    cfg_wr(2'd1, m[23:16]);
    cfg_wr(2'd2, m[15:8]);
    cfg_wr(2'd3, m[7:0]);
  endtask

  task automatic pulse(input logic [7:0] req, input logic n, input logic t, input logic r);
    src_req = req; nmi_req = n; trap_req = t; rti = r;
    tick();
    src_req = '0; nmi_req = 1'b0; trap_req = 1'b0; rti = 1'b0;
  endtask

  task automatic clear(input logic [2:0] c);
    clr_en = 1'b1; clr_code = c;
    tick();
    clr_en = 1'b0;
  endtask

  task automatic expect_irq(input string tag, input logic ev, input logic [3:0] evec);
    n_chk++;
    if (irq_valid !== ev || (ev && irq_vector !== evec)) begin
      n_fail++;
      $display("FAIL %s: valid=%0b vec=%0d expected valid=%0b vec=%0d",
               tag, irq_valid, irq_vector, ev, evec);
    end
  endtask

  task automatic expect_busy(input string tag, input logic eb);
    n_chk++;
    if (in_service !== eb) begin
      n_fail++;
      $display("FAIL %s: in_service=%0b expected %0b", tag, in_service, eb);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    expect_irq("R1 reset strobe", 1'b0, 4'd0);
    expect_busy("R1 reset idle", 1'b0);

    // reset map: only code 0 has a level
    cfg_wr(2'd0, 8'hFF);
    pulse(8'h08, 1'b0, 1'b0, 1'b0); tick();
    expect_irq("R11 unassigned code after R1 reset", 1'b0, 4'd0);
    pulse(8'h01, 1'b0, 1'b0, 1'b0); tick();
    expect_irq("R1 reset map code0", 1'b1, 4'd0);
    pulse(8'h00, 1'b0, 1'b0, 1'b1); tick();
    expect_busy("R6 return to idle", 1'b0);

    // drop stuck source 3, then give it a level
    clear(3'd3);
    map_wr(24'h053977);
    tick();
    expect_irq("R9 cleared source stays silent", 1'b0, 4'd0);

    for (int i = 0; i < 21; i++) begin
      logic [15:0] e;
      e = STEPS[i];
      pulse(e[12:5], e[13], e[14], e[15]);
      tick();
      expect_irq($sformatf("R4/R5/R6/R7/R8 step %0d", i), e[4], e[3:0]);
    end

    // masking holds a request pending
    cfg_wr(2'd0, 8'hFB);
    pulse(8'h04, 1'b0, 1'b0, 1'b0); tick();
    expect_irq("R2 masked source", 1'b0, 4'd0);
    cfg_wr(2'd0, 8'hFF); tick();
    expect_irq("R2 unmask grants", 1'b1, 4'd2);
    tick();
    expect_irq("R12 single-cycle strobe", 1'b0, 4'd0);
    pulse(8'h00, 1'b0, 1'b0, 1'b1); tick();
    expect_irq("R6 nothing waiting", 1'b0, 4'd0);

    // global enable off
    gie = 1'b0;
    pulse(8'h10, 1'b0, 1'b0, 1'b0); tick();
    expect_irq("R13 held while disabled", 1'b0, 4'd0);
    pulse(8'h00, 1'b0, 1'b1, 1'b0); tick();
    expect_irq("R7 trap while disabled", 1'b1, 4'd9);
    pulse(8'h00, 1'b0, 1'b0, 1'b1); tick();
    expect_irq("R7 trap return", 1'b0, 4'd0);
    pulse(8'h00, 1'b1, 1'b0, 1'b0); tick();
    expect_irq("R8 nmi held while disabled", 1'b0, 4'd0);
    gie = 1'b1;
    tick();
    expect_irq("R8 nmi on enable", 1'b1, 4'd8);
    pulse(8'h00, 1'b0, 1'b0, 1'b1); tick();
    expect_irq("R13 source after enable", 1'b1, 4'd4);
    pulse(8'h00, 1'b0, 1'b0, 1'b1); tick();
    expect_irq("R6 idle again", 1'b0, 4'd0);

    // map writes while busy are dropped
    pulse(8'h80, 1'b0, 1'b0, 1'b0); tick();
    expect_irq("R10 enter routine", 1'b1, 4'd7);
    map_wr(24'hFAC688);
    pulse(8'h00, 1'b0, 1'b0, 1'b1); tick();
    expect_irq("R10 return", 1'b0, 4'd0);
    pulse(8'h81, 1'b0, 1'b0, 1'b0); tick();
    expect_irq("R10 old map kept", 1'b1, 4'd0);
    pulse(8'h00, 1'b0, 1'b0, 1'b1); tick();
    expect_irq("R10 second source", 1'b1, 4'd7);
    pulse(8'h00, 1'b0, 1'b0, 1'b1); tick();
    expect_busy("R6 idle after nest", 1'b0);

    // identity map while idle: level equals code
    map_wr(24'hFAC688);
    pulse(8'h81, 1'b0, 1'b0, 1'b0); tick();
    expect_irq("R3 identity map top", 1'b1, 4'd7);
    pulse(8'h00, 1'b0, 1'b0, 1'b1); tick();
    expect_irq("R3 identity map next", 1'b1, 4'd0);
    pulse(8'h00, 1'b0, 1'b0, 1'b1); tick();

    // duplicated fields: code 4 at levels 7 and 1, code 3 elsewhere
    map_wr(24'h8DB6E3);
    pulse(8'h18, 1'b0, 1'b0, 1'b0); tick();
    expect_irq("R11 duplicate takes highest level", 1'b1, 4'd4);
    pulse(8'h00, 1'b0, 1'b0, 1'b1); tick();
    expect_irq("R11 other code next", 1'b1, 4'd3);
    pulse(8'h00, 1'b0, 1'b0, 1'b1); tick();
    pulse(8'h01, 1'b0, 1'b0, 1'b0); tick();
    expect_irq("R11 code with no level", 1'b0, 4'd0);
    clear(3'd0);
    map_wr(24'hFAC688);
    tick();
    expect_irq("R9 clear before level given", 1'b0, 4'd0);
    expect_busy("R9 idle", 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule